// File: doc/BRIEF.md
# Trigger-Delimited Hit Cluster Aggregator

This block groups a pad-ordered stream of detector hit messages into clusters. Each input message carries a pad address, a timestamp, a one-bit trigger kind and a sample payload. The trigger kind tells a pad that crossed its own threshold apart from a neighbour pad that was read out only because it sits next to such a pad. Since neighbour readouts surround every genuine cluster, they serve as the cluster boundaries. No charge or adjacency threshold is used to find them.

The block accepts one message per clock when the output is not stalled. It emits every message unchanged and in input order, and adds a first marker, a last marker and three status flags. An orphan flag marks a self-triggered message that arrives outside any cluster. A broken flag marks a cluster cut short because the next message did not continue it. An overflow flag marks a cluster truncated at the configured length. A message that sits inside an open cluster stays in the block until the next input message decides whether it is the cluster's last element.

Top module: `clag_cluster_agg`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A neighbour-kind message (in_fn=1) that arrives while no cluster is open starts a cluster and is emitted with out_first=1.
- R3: In an open cluster, the next neighbour-kind message that continues it is the cluster's final element. It is emitted with out_last=1, out_first=0 and no flag set.
- R4: A self-kind message (in_fn=0) that arrives while no cluster is open is emitted alone, with out_first=1, out_last=1 and out_orphan=1.
- R5: A message arriving in an open cluster continues it only if its pad equals the previous pad plus one, with no wrap from the top pad value to 0. Otherwise the previous message is emitted with out_last=1 and out_broken=1, and the new message is handled as if no cluster were open.
- R6: A message also fails to continue an open cluster when the absolute difference between its timestamp and the previous one exceeds TS_WIN. The outcome is the same as in R5. A difference equal to TS_WIN still continues the cluster.
- R7: A self-kind message that brings the cluster length to MAX_LEN is emitted with out_last=1 and out_overflow=1. A neighbour-kind message at length MAX_LEN closes the cluster normally, without the overflow flag.
- R8: Pad, timestamp, trigger kind and samples leave exactly as they entered. Each input message produces exactly one output message, and input order is kept.
- R9: A low out_ready holds the output message stable. No message is lost or repeated. While out_ready stays 1, in_ready stays 1, so one message is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Block can accept an input message |
| in_pad | input | PAD_W | Pad address, ordered by position |
| in_ts | input | TS_W | Message timestamp |
| in_fn | input | 1 | Trigger kind: 1 = neighbour readout, 0 = self trigger |
| in_samples | input | NSAMP*SAMP_W | Signal samples |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Downstream accepts the output message |
| out_pad | output | PAD_W | Pad address |
| out_ts | output | TS_W | Timestamp |
| out_fn | output | 1 | Trigger kind |
| out_samples | output | NSAMP*SAMP_W | Signal samples |
| out_first | output | 1 | First element of a cluster |
| out_last | output | 1 | Last element of a cluster |
| out_orphan | output | 1 | Self-kind message outside any cluster |
| out_broken | output | 1 | Cluster ended by a discontinuity |
| out_overflow | output | 1 | Cluster ended by the length limit |

## Verification
One input message can close a cluster and also start the next one in the same cycle. When a message breaks continuity, it marks the held message as last and broken, and it opens a new cluster or becomes an orphan itself. The bench provokes this with pad gaps, with timestamp jumps just past the window, and with a neighbour message used as the breaker. Some of these cases run while out_ready toggles, so the resolution coincides with a stalled output. A sequential model built from the requirements gives the expected first, last and flag bits for every message, and each emitted message is compared against it in order.

// File: rtl/clag_pkg.sv
package clag_pkg;

  typedef struct packed {
    logic orphan;
    logic broken;
    logic ovf;
  } clag_flags_t;

endpackage

// File: rtl/clag_link_check.sv
module clag_link_check #(
  parameter int PAD_W  = 8,
  parameter int TS_W   = 16,
  parameter int TS_WIN = 4
) (
  input  logic [PAD_W-1:0] prev_pad,
  input  logic [TS_W-1:0]  prev_ts,
  input  logic [PAD_W-1:0] cur_pad,
  input  logic [TS_W-1:0]  cur_ts,
  output logic             pad_ok,
  output logic             ts_ok
);
  localparam logic [TS_W:0] WIN_EXT = (TS_W+1)'(TS_WIN);

  logic [PAD_W:0] next_pad;
  logic [TS_W-1:0] ts_gap;

  always_comb begin
    next_pad = {1'b0, prev_pad} + (PAD_W+1)'(1);
    pad_ok   = (next_pad == {1'b0, cur_pad});
    ts_gap   = (cur_ts >= prev_ts) ? (cur_ts - prev_ts) : (prev_ts - cur_ts);
    ts_ok    = ({1'b0, ts_gap} <= WIN_EXT);
  end

endmodule

// File: rtl/clag_hold.sv
module clag_hold
  import clag_pkg::*;
#(
  parameter int PAD_W   = 8,
  parameter int TS_W    = 16,
  parameter int DAT_W   = 288,
  parameter int MAX_LEN = 8,
  parameter int TS_WIN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAD_W-1:0] in_pad,
  input  logic [TS_W-1:0]  in_ts,
  input  logic             in_fn,
  input  logic [DAT_W-1:0] in_dat,
  input  logic             dn_free,
  output logic             dn_push,
  output logic [PAD_W-1:0] dn_pad,
  output logic [TS_W-1:0]  dn_ts,
  output logic             dn_fn,
  output logic [DAT_W-1:0] dn_dat,
  output logic             dn_first,
  output logic             dn_last,
  output clag_flags_t      dn_flags
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

  // Held message: last accepted element whose end marker may be pending
  logic             h_v;
  logic             h_final;   // end marker already decided
  logic             h_first;
  logic [PAD_W-1:0] h_pad;
  logic [TS_W-1:0]  h_ts;
  logic             h_fn;
  logic [DAT_W-1:0] h_dat;
  clag_flags_t      h_flags;
  logic [CNT_W-1:0] cnt;

  logic open_c, in_fire, joins, pad_ok, ts_ok;
  logic [CNT_W-1:0] cnt_inc;

  clag_link_check #(
    .PAD_W (PAD_W),
    .TS_W  (TS_W),
    .TS_WIN(TS_WIN)
  ) u_link (
    .prev_pad(h_pad),
    .prev_ts (h_ts),
    .cur_pad (in_pad),
    .cur_ts  (in_ts),
    .pad_ok  (pad_ok),
    .ts_ok   (ts_ok)
  );

  always_comb begin
    open_c   = h_v && !h_final;
    in_ready = !h_v || dn_free;
    in_fire  = in_valid && in_ready;
    joins    = open_c && pad_ok && ts_ok;
    cnt_inc  = cnt + CNT_W'(1);
    dn_push  = h_v && dn_free && (h_final || in_fire);
    dn_pad   = h_pad;
    dn_ts    = h_ts;
    dn_fn    = h_fn;
    dn_dat   = h_dat;
    dn_first = h_first;
    dn_last  = h_final || (in_fire && !joins);
    dn_flags = h_flags;
    dn_flags.broken = h_flags.broken || (open_c && in_fire && !joins);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_v     <= 1'b0;
      h_final <= 1'b0;
      h_first <= 1'b0;
      h_flags <= '0;
      cnt     <= '0;
    end else if (in_fire) begin
      h_v     <= 1'b1;
      h_pad   <= in_pad;
      h_ts    <= in_ts;
      h_fn    <= in_fn;
      h_dat   <= in_dat;
      h_flags <= '0;
      if (joins) begin
        h_first <= 1'b0;
        cnt     <= cnt_inc;
        if (in_fn) begin
          h_final <= 1'b1;
        end else if (cnt_inc == MAX_C) begin
          h_final     <= 1'b1;
          h_flags.ovf <= 1'b1;
        end else begin
          h_final <= 1'b0;
        end
      end else begin
        h_first <= 1'b1;
        if (in_fn) begin
          cnt     <= CNT_W'(1);
          h_final <= 1'b0;
        end else begin
          cnt            <= '0;
          h_final        <= 1'b1;
          h_flags.orphan <= 1'b1;
        end
      end
    end else if (dn_push) begin
      h_v <= 1'b0;
    end
  end

  // An open cluster always has a length between one and MAX_LEN-1
  p_open_len_r7: assert property (@(posedge clk) disable iff (rst)
    open_c |-> (cnt != '0 && cnt < MAX_C));

  // The held message leaves whenever a new one takes its place
  p_no_loss_r9: assert property (@(posedge clk) disable iff (rst)
    (in_fire && h_v) |-> dn_push);

  // A fresh neighbour message opens a cluster held as its first element
  p_fn_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !joins && in_fn) |=> (h_v && h_first && !h_final));

endmodule

// File: rtl/clag_out_reg.sv
module clag_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_push,
  input  logic [W-1:0] up_data,
  output logic         up_free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_comb up_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (up_push) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (up_push) out_data <= up_data;
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/clag_cluster_agg.sv
module clag_cluster_agg
  import clag_pkg::*;
#(
  parameter int PAD_W   = 8,
  parameter int TS_W    = 16,
  parameter int NSAMP   = 32,
  parameter int SAMP_W  = 9,
  parameter int MAX_LEN = 8,
  parameter int TS_WIN  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PAD_W-1:0]        in_pad,
  input  logic [TS_W-1:0]         in_ts,
  input  logic                    in_fn,
  input  logic [NSAMP*SAMP_W-1:0] in_samples,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [PAD_W-1:0]        out_pad,
  output logic [TS_W-1:0]         out_ts,
  output logic                    out_fn,
  output logic [NSAMP*SAMP_W-1:0] out_samples,
  output logic                    out_first,
  output logic                    out_last,
  output logic                    out_orphan,
  output logic                    out_broken,
  output logic                    out_overflow
);
  localparam int DAT_W = NSAMP * SAMP_W;
  localparam int REC_W = PAD_W + TS_W + 1 + DAT_W + 2 + 3;

  logic             dn_free, dn_push, dn_fn, dn_first, dn_last;
  logic [PAD_W-1:0] dn_pad;
  logic [TS_W-1:0]  dn_ts;
  logic [DAT_W-1:0] dn_dat;
  clag_flags_t      dn_flags;
  logic [REC_W-1:0] rec_in, rec_out;

  clag_hold #(
    .PAD_W  (PAD_W),
    .TS_W   (TS_W),
    .DAT_W  (DAT_W),
    .MAX_LEN(MAX_LEN),
    .TS_WIN (TS_WIN)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_pad  (in_pad),
    .in_ts   (in_ts),
    .in_fn   (in_fn),
    .in_dat  (in_samples),
    .dn_free (dn_free),
    .dn_push (dn_push),
    .dn_pad  (dn_pad),
    .dn_ts   (dn_ts),
    .dn_fn   (dn_fn),
    .dn_dat  (dn_dat),
    .dn_first(dn_first),
    .dn_last (dn_last),
    .dn_flags(dn_flags)
  );

  always_comb rec_in = {dn_pad, dn_ts, dn_fn, dn_dat, dn_first, dn_last, dn_flags};

  clag_out_reg #(.W(REC_W)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .up_push  (dn_push),
    .up_data  (rec_in),
    .up_free  (dn_free),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (rec_out)
  );

  always_comb begin
    {out_pad, out_ts, out_fn, out_samples, out_first, out_last,
     out_orphan, out_broken, out_overflow} = rec_out;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  p_orphan_single_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_orphan) |-> (out_first && out_last && !out_fn));

  p_broken_last_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_broken) |-> out_last);

  p_ovf_last_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |-> (out_last && !out_fn && !out_broken));

  p_full_rate_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);

endmodule

// File: tb/clag_cluster_agg_tb.sv
module clag_cluster_agg_tb;
  localparam int PAD_W = 6, TS_W = 8, NSAMP = 4, SAMP_W = 8, MAX_LEN = 5, TS_WIN = 3;
  localparam int DAT_W = NSAMP * SAMP_W;
  localparam int NMAX = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_fn = 1'b0, out_ready = 1'b0;
  logic [PAD_W-1:0] in_pad = '0, out_pad;
  logic [TS_W-1:0] in_ts = '0, out_ts;
  logic [DAT_W-1:0] in_samples = '0, out_samples;
  logic out_valid, out_fn, out_first, out_last, out_orphan, out_broken, out_overflow;

  always #10 clk = ~clk;

  clag_cluster_agg #(.PAD_W(PAD_W), .TS_W(TS_W), .NSAMP(NSAMP), .SAMP_W(SAMP_W),
                     .MAX_LEN(MAX_LEN), .TS_WIN(TS_WIN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pad(in_pad),
    .in_ts(in_ts), .in_fn(in_fn), .in_samples(in_samples), .out_valid(out_valid),
    .out_ready(out_ready), .out_pad(out_pad), .out_ts(out_ts), .out_fn(out_fn),
    .out_samples(out_samples), .out_first(out_first), .out_last(out_last),
    .out_orphan(out_orphan), .out_broken(out_broken), .out_overflow(out_overflow));

  int s_pad [NMAX];
  int s_ts  [NMAX];
  bit s_fn  [NMAX];
  bit e_first[NMAX], e_last[NMAX], e_orph[NMAX], e_brk[NMAX], e_brk_ts[NMAX], e_ovf[NMAX];
  int n = 0;
  int checks = 0, fails = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit model_open;

  function automatic logic [DAT_W-1:0] dat_of(int i);
    return {8'(i), 8'(s_pad[i]), 8'(s_ts[i]), 8'(i * 7 + 3)};
  endfunction

  task automatic add(int pad, int ts, bit fn);
    s_pad[n] = pad; s_ts[n] = ts; s_fn[n] = fn; n++;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(bit ok, string tag, int act, int exp, int idx);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s msg %0d: actual %0d expected %0d", tag, idx, act, exp);
    end
  endtask

  // Expected markers from the requirements, one pass over the stimulus
  task automatic run_model();
    int cnt = 0, pp = 0, pt = 0;
    bit fits;
    model_open = 0;
    for (int i = 0; i < n; i++) begin
      e_first[i] = 0; e_last[i] = 0; e_orph[i] = 0; e_brk[i] = 0; e_brk_ts[i] = 0; e_ovf[i] = 0;
    end
    for (int i = 0; i < n; i++) begin
      int d = s_ts[i] - pt;
      if (d < 0) d = -d;
      fits = model_open && (s_pad[i] == pp + 1) && (d <= TS_WIN);
      if (model_open && !fits) begin
        e_last[i-1] = 1; e_brk[i-1] = 1;
        e_brk_ts[i-1] = (s_pad[i] == pp + 1);
        model_open = 0;
      end
      if (fits) begin
        cnt++;
        if (s_fn[i]) begin e_last[i] = 1; model_open = 0; end
        else if (cnt == MAX_LEN) begin e_last[i] = 1; e_ovf[i] = 1; model_open = 0; end
      end else begin
        e_first[i] = 1;
        if (s_fn[i]) begin model_open = 1; cnt = 1; end
        else begin e_last[i] = 1; e_orph[i] = 1; end
      end
      pp = s_pad[i]; pt = s_ts[i];
    end
  endtask

  task automatic check_out(int i);
    chk(out_pad == PAD_W'(s_pad[i]), "R8 pad", int'(out_pad), s_pad[i], i);
    chk(out_ts == TS_W'(s_ts[i]), "R8 ts", int'(out_ts), s_ts[i], i);
    chk(out_fn == s_fn[i], "R8 kind", int'(out_fn), int'(s_fn[i]), i);
    chk(out_samples == dat_of(i), "R8 samples", int'(out_samples), int'(dat_of(i)), i);
    chk(out_first == e_first[i], s_fn[i] ? "R2 first" : "R4 first", int'(out_first), int'(e_first[i]), i);
    chk(out_last == e_last[i], "R3 last", int'(out_last), int'(e_last[i]), i);
    chk(out_orphan == e_orph[i], "R4 orphan", int'(out_orphan), int'(e_orph[i]), i);
    chk(out_broken == e_brk[i], e_brk_ts[i] ? "R6 broken" : "R5 broken", int'(out_broken), int'(e_brk[i]), i);
    chk(out_overflow == e_ovf[i], "R7 overflow", int'(out_overflow), int'(e_ovf[i]), i);
  endtask

  initial begin
    int idx_in = 0, idx_out = 0, cyc = 0, pad = 0, ts = 0;
    bit steady, drive;

    // Directed: normal cluster, orphan, pad gap, window edge, breaker that opens
    add(1,10,1); add(2,11,0); add(3,12,0); add(4,12,1);
    add(10,20,0);
    add(20,30,1); add(21,31,0); add(23,31,0);
    add(30,40,1); add(31,43,0); add(32,47,0);
    add(40,60,1); add(41,60,0); add(45,60,1); add(46,61,1);
    // Length limit: self at MAX_LEN overflows, neighbour at MAX_LEN closes cleanly
    add(50,1,1); add(51,1,0); add(52,1,0); add(53,1,0); add(54,1,0); add(55,1,0);
    add(0,5,1); add(1,5,1);
    add(5,9,1); add(6,9,0); add(7,9,0); add(8,9,0); add(9,9,1);
    // No wrap of pad address
    add(62,9,1); add(63,9,0); add(0,9,0);
    // Breaker by timestamp jump backwards
    add(10,100,1); add(11,96,1);
    // Pseudo-random body
    pad = 2; ts = 50;
    for (int k = 0; k < 640; k++) begin
      step_lfsr();
      if (lfsr[3:0] == 4'd0 || pad >= 58) pad = int'(lfsr[8:4]);
      else pad = pad + 1;
      case (lfsr[11:10])
        2'd0: ts = ts + int'(lfsr[13:12]);
        2'd1: ts = ts - int'(lfsr[13:12]);
        2'd2: ts = ts + TS_WIN;
        default: ts = ts + ((lfsr[14]) ? TS_WIN + 1 : 0);
      endcase
      ts = ts & 8'hFF;
      add(pad, ts, lfsr[15] ^ lfsr[2] ^ (lfsr[1] & lfsr[0]));
    end
    run_model();
    if (model_open) begin
      add(s_pad[n-1] + 1, s_ts[n-1], 1);
      run_model();
    end

    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0, -1);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1, -1);

    while (idx_out < n) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R9 watchdog", idx_out, n, -1);
        break;
      end
      step_lfsr();
      steady = (idx_in >= 200 && idx_in < 400);
      out_ready = steady ? 1'b1 : (lfsr[1:0] != 2'b00);
      drive = (idx_in < n) && (steady || lfsr[5:4] != 2'b00);
      in_valid = drive;
      if (drive) begin
        in_pad = PAD_W'(s_pad[idx_in]); in_ts = TS_W'(s_ts[idx_in]);
        in_fn = s_fn[idx_in]; in_samples = dat_of(idx_in);
      end
      #1;
      if (steady && in_valid) chk(in_ready == 1'b1, "R9 full rate", int'(in_ready), 1, idx_in);
      if (out_valid && out_ready) begin
        check_out(idx_out);
        idx_out++;
      end
      if (in_valid && in_ready) idx_in++;
    end

    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (20) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R9 no repeat", int'(out_valid), 0, idx_out);
    end
    chk(idx_in == n, "R9 all accepted", idx_in, n, -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule